// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is a memory-mapped counter/timer, one copy per processor. Software reaches it through a 32-bit word interface with a read strobe, a write strobe and a registered read-data return. It has a single interrupt output. An internal prescaler produces the count tick, standing in for a 500 ns time base, and the counter advances by one on each tick.

The mode input selects one of two personalities. In limit mode the block is a periodic interrupt source. The counter climbs to a programmable limit, wraps to zero, sets a reached flag and raises the interrupt. Software acknowledges by reading the limit word. In user mode the same storage becomes a 54-bit free-running counter that software can stop and start. This counter never interrupts and is read as a high word and a low word. Reading the high word captures the low word, so a high-then-low pair is coherent.

Counts sit in word bits 30:9 (limit mode), or in bits 62:9 of the 64-bit pair (user mode). The bits below 9 always read as zero. The word offset is taken from address bits 4:2.

Top module: `ctmr_cpu_timer`

## Requirements
- R1: After reset the count and the reached flag are zero, the interrupt is low and the counter is running (offset 3 reads 1). In limit mode offset 0 reads 0x7FFFFE00.
- R2: The count rises by exactly one every TICK_DIV clocks. It is presented in word bits 30:9, and bits 8:0 read zero.
- R3: In limit mode a read of offset 0 returns the limit in bits 30:9 with bit 31 zero. The read clears the reached flag and lowers the interrupt.
- R4: In limit mode a read of offset 1 returns the count in bits 30:9 and the reached flag in bit 31.
- R5: In limit mode a write to offset 0 stores bits 30:9 of the data as the limit, clears the count and lowers the interrupt.
- R6: A write to offset 2 stores a new limit and leaves the count untouched. A zero limit written at offset 0 or 2 becomes 0x7FFFFE00.
- R7: In limit mode, a tick that would bring the count to or past the limit wraps the count to zero, sets the reached flag and raises the interrupt.
- R8: A wrap wins over a limit read in the same cycle, so the interrupt stays high. A counter-clearing write wins over a tick in the same cycle.
- R9: In user mode the interrupt stays low. Offset 0 reads count bits 53:23 in word bits 30:0. Offset 1 reads count bits 22:0 in word bits 31:9. After a high-word read, the next low-word read returns the low word captured at that high-word read.
- R10: In user mode a write to offset 0 or offset 1 clears the count.
- R11: In user mode a write to offset 3 sets the running flag to data bit 0, and a stopped counter holds its value. In limit mode the write is ignored. Offset 3 reads the running flag in bit 0.
- R12: A change of the mode input clears the count and the reached flag and lowers the interrupt.
- R13: Offsets 2 and 4 to 7 read zero. Writes to offsets 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode_i | input | 1 | 1 selects user (free-running) mode, 0 selects limit mode |
| addr_i | input | ADDR_W | Byte address; bits 4:2 give the word offset |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt, level high |

## Verification
Two events can fall in the same cycle: a wrap of the counter at the limit, and a software access that clears status or resets the count. A behavioural model in the bench tracks the prescaler phase. The bench uses it to hold off until the very cycle whose tick completes the limit, then issues the acknowledging read of offset 0 in that cycle. The interrupt must then stay high and the next count read must show bit 31 set. The same cycle-exact aim places a limit write on a tick cycle, and the following count read must show zero rather than one.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
   localparam int OFS_W = 3;

   localparam logic [OFS_W-1:0] OFS_LIMIT   = 3'd0;
   localparam logic [OFS_W-1:0] OFS_COUNT   = 3'd1;
   localparam logic [OFS_W-1:0] OFS_LIM_NR  = 3'd2;
   localparam logic [OFS_W-1:0] OFS_RUNCTL  = 3'd3;

   typedef struct packed {
      logic sel_lim;
      logic sel_cnt;
      logic sel_lnr;
      logic sel_run;
   } ctmr_dec_t;

   function automatic ctmr_dec_t ctmr_decode(input logic [OFS_W-1:0] ofs);
      ctmr_dec_t d;
      d.sel_lim = (ofs == OFS_LIMIT);
      d.sel_cnt = (ofs == OFS_COUNT);
      d.sel_lnr = (ofs == OFS_LIM_NR);
      d.sel_run = (ofs == OFS_RUNCTL);
      return d;
   endfunction
endpackage

// File: rtl/ctmr_tick_gen.sv
module ctmr_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("ctmr_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      logic unused_tick_pins;
      assign unused_tick_pins = clk ^ rst_n;
      assign tick_o = 1'b1;
   end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              phase_q <= '0;
         else if (phase_q == LAST) phase_q <= '0;
         else                     phase_q <= phase_q + 1'b1;
      end

      assign tick_o = (phase_q == LAST);
   end
endmodule

// File: rtl/ctmr_count_core.sv
module ctmr_count_core #(
   parameter int CNT_W = 54,
   parameter int LIM_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             user_i,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [LIM_W-1:0] limit_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);
   if (LIM_W >= CNT_W) begin : g_bad_w
      $error("ctmr_count_core: LIM_W must be narrower than CNT_W");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] lim_ext;
   logic             adv, hit_lim, hit_usr;

   assign lim_ext = {{(CNT_W-LIM_W){1'b0}}, limit_i};
   assign adv     = tick_i && (!user_i || run_i) && !clr_i;
   assign nxt     = cnt_q + 1'b1;
   assign hit_lim = (nxt >= lim_ext);
   assign hit_usr = (nxt == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (adv) begin
         if (user_i ? hit_usr : hit_lim) cnt_q <= '0;
         else                            cnt_q <= nxt;
      end
   end

   assign count_o = cnt_q;
   assign wrap_o  = adv && !user_i && hit_lim;

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (user_i && !run_i && !clr_i) |=> $stable(cnt_q)); // R11
   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0)); // R10
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
   import ctmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LSB    = 9,
   parameter int CNT_W  = 54,
   parameter int LIM_W  = 22,
   parameter bit HI_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              user_i,
   input  logic              chg_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              wrap_i,
   output logic [LIM_W-1:0]  limit_o,
   output logic              run_o,
   output logic              clr_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   localparam int LO_W = DATA_W - LSB;

   ctmr_dec_t        dec;
   logic [LIM_W-1:0] limit_q, lim_new, lim_d;
   logic             lim_wr, rd_ack;
   logic             run_q, reached_q, irq_q;
   logic [LO_W-1:0]  lo_live, lo_view;
   logic [DATA_W-1:0] rd_d, rdata_q;
   logic             unused_wdata;

   assign dec          = ctmr_decode(ofs_i);
   assign unused_wdata = ^{wdata_i[DATA_W-1], wdata_i[LSB-1:1]};

   // counter clear: mode change, limit write, or user-word write
   assign clr_o  = chg_i || (wr_i && (dec.sel_lim || (user_i && dec.sel_cnt)));
   assign rd_ack = rd_i && !user_i && dec.sel_lim;

   // limit store
   assign lim_wr  = wr_i && ((dec.sel_lim && !user_i) || dec.sel_lnr);
   assign lim_new = wdata_i[DATA_W-2:LSB];
   assign lim_d   = (lim_new == '0) ? {LIM_W{1'b1}} : lim_new;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      limit_q <= {LIM_W{1'b1}};
      else if (lim_wr) limit_q <= lim_d;
   end

   // run control, user mode only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            run_q <= 1'b1;
      else if (wr_i && user_i && dec.sel_run) run_q <= wdata_i[0];
   end

   // status: a wrap in the same cycle beats every clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reached_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         if (wrap_i)                  reached_q <= 1'b1;
         else if (chg_i || rd_ack)    reached_q <= 1'b0;
         if (wrap_i)                  irq_q <= 1'b1;
         else if (clr_o || rd_ack)    irq_q <= 1'b0;
      end
   end

   assign lo_live = count_i[LO_W-1:0];

   if (HI_LATCH) begin : g_latch
      logic [LO_W-1:0] lo_q;
      logic            lo_v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q   <= '0;
            lo_v_q <= 1'b0;
         end else if (clr_o) begin
            lo_v_q <= 1'b0;
         end else if (rd_i && user_i && dec.sel_lim) begin
            lo_q   <= lo_live;
            lo_v_q <= 1'b1;
         end else if (rd_i && user_i && dec.sel_cnt) begin
            lo_v_q <= 1'b0;
         end
      end
      assign lo_view = lo_v_q ? lo_q : lo_live;
   end else begin : g_nolatch
      assign lo_view = lo_live;
   end

   // read mux
   always_comb begin
      rd_d = '0;
      if (dec.sel_lim) begin
         if (user_i) rd_d = {1'b0, count_i[CNT_W-1:LO_W]};
         else        rd_d = {1'b0, limit_q, {LSB{1'b0}}};
      end else if (dec.sel_cnt) begin
         if (user_i) rd_d = {lo_view, {LSB{1'b0}}};
         else        rd_d = {reached_q, count_i[LIM_W-1:0], {LSB{1'b0}}};
      end else if (dec.sel_run) begin
         rd_d = {{(DATA_W-1){1'b0}}, run_q};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_d;
   end

   assign limit_o = limit_q;
   assign run_o   = run_q;
   assign rdata_o = rdata_q;
   assign irq_o   = irq_q;

   AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      limit_q != '0); // R6
   AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> (irq_q && reached_q)); // R8
   AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !wrap_i) |=> (!irq_q && !reached_q)); // R3
   AST_RUNCTL_LIMIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!user_i && wr_i && dec.sel_run) |=> $stable(run_q)); // R11
endmodule

// File: rtl/ctmr_cpu_timer.sv
module ctmr_cpu_timer
   import ctmr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int LSB      = 9,
   parameter int TICK_DIV = 4,
   parameter bit HI_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              user_mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   localparam int LIM_W = DATA_W - 1 - LSB;
   localparam int CNT_W = 2*DATA_W - 1 - LSB;

   if (DATA_W != 32) begin : g_bad_data
      $error("ctmr_cpu_timer: DATA_W must be 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ctmr_cpu_timer: ADDR_W must be at least 5");
   end
   if (LSB < 1 || LSB > 16) begin : g_bad_lsb
      $error("ctmr_cpu_timer: LSB out of range");
   end

   logic             tick, user_q, chg, clr, wrap, run;
   logic [LIM_W-1:0] limit;
   logic [CNT_W-1:0] count;
   logic [OFS_W-1:0] ofs;
   logic             unused_addr;

   assign ofs         = addr_i[OFS_W+1:2];
   assign unused_addr = ^{addr_i[1:0], addr_i[ADDR_W-1:OFS_W+2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) user_q <= 1'b0;
      else        user_q <= user_mode_i;
   end
   assign chg = (user_mode_i != user_q);

   ctmr_tick_gen #(.DIV(TICK_DIV)) i_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick)
   );

   ctmr_count_core #(.CNT_W(CNT_W), .LIM_W(LIM_W)) i_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .user_i(user_mode_i),
      .run_i(run), .clr_i(clr), .limit_i(limit),
      .count_o(count), .wrap_o(wrap)
   );

   ctmr_regs #(
      .DATA_W(DATA_W), .LSB(LSB), .CNT_W(CNT_W), .LIM_W(LIM_W), .HI_LATCH(HI_LATCH)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .user_i(user_mode_i), .chg_i(chg),
      .ofs_i(ofs), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
      .count_i(count), .wrap_i(wrap), .limit_o(limit), .run_o(run),
      .clr_o(clr), .rdata_o(rdata_o), .irq_o(irq_o)
   );

   AST_USER_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode_i |=> !irq_o); // R9
   AST_MODE_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !irq_o); // R12
endmodule

// File: tb/test_ctmr_cpu_timer.sv
module test_ctmr_cpu_timer;
   localparam int TDIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        user_mode = 1'b0;
   logic [4:0]  addr = '0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   ctmr_cpu_timer #(.TICK_DIV(TDIV)) i_ctmr_cpu_timer (
      .clk(clk), .rst_n(rst_n), .user_mode_i(user_mode), .addr_i(addr),
      .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   // ---------------- behavioural reference model ----------------
   longint m_cnt, m_lat;
   int     m_lim, m_pre;
   bit     m_reached, m_irq, m_run, m_latv, m_uq, m_rdv;
   logic [31:0] m_rd;
   localparam longint USR_TOP = (64'd1 << 54) - 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_lat = 0; m_lim = 32'h3FFFFF; m_pre = 0;
         m_reached = 0; m_irq = 0; m_run = 1; m_latv = 0; m_uq = 0;
         m_rdv = 0; m_rd = 0;
      end else begin
         int  ofs;
         bit  tick, chg, clr, wrapped, ack;
         longint n;
         ofs  = int'(addr[4:2]);
         tick = (m_pre == TDIV-1);
         m_pre = tick ? 0 : m_pre + 1;
         chg = (user_mode != m_uq);
         m_uq = user_mode;
         clr = chg || (wr && (ofs == 0 || (user_mode && ofs == 1)));
         ack = rd && !user_mode && ofs == 0;
         m_rdv = rd;
         if (rd) begin
            case (ofs)
               0: m_rd = user_mode ? 32'((m_cnt >> 23) & 64'h7FFFFFFF) : 32'(m_lim) << 9;
               1: m_rd = user_mode ? (32'(m_latv ? m_lat : (m_cnt & 64'h7FFFFF)) << 9)
                                   : ({m_reached, 31'd0} | (32'(m_cnt & 64'h3FFFFF) << 9));
               3: m_rd = {31'd0, m_run};
               default: m_rd = 0;
            endcase
         end
         if (clr) m_latv = 0;
         else if (rd && user_mode && ofs == 0) begin m_latv = 1; m_lat = m_cnt & 64'h7FFFFF; end
         else if (rd && user_mode && ofs == 1) m_latv = 0;
         wrapped = 0;
         if (clr) m_cnt = 0;
         else if (tick && (!user_mode || m_run)) begin
            n = m_cnt + 1;
            if (user_mode) m_cnt = (n == USR_TOP) ? 0 : n;
            else if (n >= m_lim) begin m_cnt = 0; wrapped = 1; end
            else m_cnt = n;
         end
         if (chg || ack) m_reached = 0;
         if (clr || ack) m_irq = 0;
         if (wrapped) begin m_reached = 1; m_irq = 1; end
         if (wr && ((ofs == 0 && !user_mode) || ofs == 2))
            m_lim = (wdata[30:9] == 0) ? 32'h3FFFFF : int'(wdata[30:9]);
         if (wr && user_mode && ofs == 3) m_run = wdata[0];
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, "irq per-cycle", {31'd0, irq}, {31'd0, m_irq});
         if (m_rdv) chk(cur_req, "rdata per-read", rdata, m_rd);
      end
   end

   task automatic rd_word(input int ofs, output logic [31:0] v);
      addr = 5'(ofs << 2); rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      v = rdata;
   endtask

   task automatic wr_word(input int ofs, input logic [31:0] d);
      addr = 5'(ofs << 2); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_wrap_cycle();
      while (!(m_pre == TDIV-1 && !user_mode && m_cnt + 1 >= m_lim)) @(negedge clk);
   endtask

   task automatic wait_tick_cycle();
      while (m_pre != TDIV-1) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v, a, b;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      cur_req = "R1";
      chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
      rd_word(0, v); chk("R1", "reset limit", v, 32'h7FFFFE00);
      rd_word(3, v); chk("R1", "reset running", v, 32'd1);
      rd_word(1, v); chk("R1", "reset reached", {31'd0, v[31]}, 32'd0);

      cur_req = "R13";
      rd_word(2, v); chk("R13", "offset 2 read", v, 32'd0);
      rd_word(6, v); chk("R13", "offset 6 read", v, 32'd0);
      wr_word(5, 32'h0000_0400);
      wr_word(7, 32'h0000_0000);
      rd_word(0, v); chk("R13", "limit after stray writes", v, 32'h7FFFFE00);

      cur_req = "R2";
      rd_word(1, a);
      idle(8*TDIV - 1);
      rd_word(1, b);
      chk("R2", "ticks in 8*TDIV clocks", (b - a) >> 9, 32'd8);
      chk("R2", "low bits zero", b & 32'h1FF, 32'd0);

      cur_req = "R5";
      wr_word(0, 32'h8000_0BFF);  // field 5
      rd_word(1, v); chk("R5", "count after limit write", v & 32'h7FFFFE00, 32'd0);
      rd_word(0, v); chk("R5", "masked limit", v, 32'h0000_0A00);

      cur_req = "R7";
      while (!irq) @(negedge clk);
      rd_word(1, v); chk("R4", "reached bit after wrap", {31'd0, v[31]}, 32'd1);
      chk("R7", "irq raised by wrap", {31'd0, irq}, 32'd1);

      cur_req = "R3";
      rd_word(0, v); chk("R3", "limit read value", v, 32'h0000_0A00);
      chk("R3", "irq cleared by limit read", {31'd0, irq}, 32'd0);
      rd_word(1, v); chk("R3", "reached cleared", {31'd0, v[31]}, 32'd0);

      cur_req = "R6";
      wr_word(2, 32'd0);
      rd_word(0, v); chk("R6", "zero at offset 2 -> max", v, 32'h7FFFFE00);
      wr_word(0, 32'd0);
      rd_word(0, v); chk("R6", "zero at offset 0 -> max", v, 32'h7FFFFE00);
      idle(6*TDIV);
      rd_word(1, a);
      wr_word(2, 32'h0000_4000);
      rd_word(1, b);
      chk("R6", "offset 2 keeps count", {31'd0, b >= a}, 32'd1);
      rd_word(0, v); chk("R6", "offset 2 limit", v, 32'h0000_4000);

      cur_req = "R8";
      wr_word(0, 32'h0000_0600);  // field 3
      wait_wrap_cycle();
      rd_word(0, v);
      chk("R8", "irq kept when wrap meets ack", {31'd0, irq}, 32'd1);
      rd_word(1, v); chk("R8", "reached kept when wrap meets ack", {31'd0, v[31]}, 32'd1);
      rd_word(0, v);
      wr_word(0, 32'h0000_2000);
      idle(2);
      wait_tick_cycle();
      wr_word(0, 32'h0000_2000);
      rd_word(1, v); chk("R8", "write beats tick", v, 32'd0);

      cur_req = "R12";
      wr_word(0, 32'h0000_0400);
      while (!irq) @(negedge clk);
      user_mode = 1'b1;
      @(negedge clk);
      chk("R12", "irq lowered on mode change", {31'd0, irq}, 32'd0);
      rd_word(1, v); chk("R12", "count cleared on mode change", {31'd0, v < 32'h800}, 32'd1);

      cur_req = "R9";
      idle(200);
      chk("R9", "no irq in user mode", {31'd0, irq}, 32'd0);
      rd_word(0, a); chk("R9", "high word", a, 32'd0);
      idle(5*TDIV);
      rd_word(1, b);
      rd_word(1, v);
      chk("R9", "latched low older than live", {31'd0, v > b}, 32'd1);
      chk("R9", "low bits zero", b & 32'h1FF, 32'd0);

      cur_req = "R10";
      wr_word(1, 32'hFFFF_FFFF);
      rd_word(1, v); chk("R10", "offset 1 write clears", v, 32'd0);
      idle(10*TDIV);
      wr_word(0, 32'd0);
      rd_word(1, v); chk("R10", "offset 0 write clears", v, 32'd0);

      cur_req = "R11";
      idle(4*TDIV);
      wr_word(3, 32'd0);
      rd_word(3, v); chk("R11", "stopped flag", v, 32'd0);
      rd_word(1, a);
      idle(10*TDIV);
      rd_word(1, b); chk("R11", "stopped count holds", b, a);
      wr_word(3, 32'd0);
      rd_word(3, v); chk("R11", "repeat stop no effect", v, 32'd0);
      wr_word(3, 32'd1);
      idle(4*TDIV);
      rd_word(1, b); chk("R11", "restarted count moves", {31'd0, b > a}, 32'd1);
      rd_word(3, v); chk("R11", "running flag", v, 32'd1);
      user_mode = 1'b0;
      idle(2);
      wr_word(3, 32'd0);
      rd_word(3, v); chk("R11", "limit mode ignores stop", v, 32'd1);

      cur_req = "R4";
      rd_word(1, v); chk("R4", "count read reached clear", {31'd0, v[31]}, 32'd0);
      idle(20);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule